// File: doc/BRIEF.md
# Triple Parallel Port Controller

This block gives a host processor three 8-bit general-purpose parallel ports, called A, B and C, behind a four-register window. Port C counts as two 4-bit halves whose directions are chosen on their own. The host drives an 8-bit write bus and samples an 8-bit read bus. An active-low select and active-low read and write strobes qualify each access, and two address bits pick the register. Every port bit has an output value and an input value, and each direction group has an output-enable. Pad drivers outside the block join these into bidirectional pins.

All host activity is synchronous to `clk`. A write is taken on every rising edge at which select and the write strobe are both low. A read is combinational while select and the read strobe are both low, and the read bus is zero at all other times. The control address accepts two kinds of word. One redefines the direction of every group. The other sets or clears a single port C bit without touching the rest. Only simple latched-output / live-input operation is provided. Handshake and bidirectional-bus modes are covered by other logic.

Top module: `gpio_triport`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output-enable goes to 0, every output latch goes to 0, and the stored control word becomes 8'h9B.
- R2: `addr` selects the register: 0 is port A data, 1 is port B data, 2 is port C data, and 3 is the control word.
- R3: While `cs_n` is high, a low `wr_n` changes no latch and no control state, and `rdata` reads 0. `rdata` is also 0 whenever `rd_n` is high.
- R4: A control write with bit 7 = 1 sets the directions from the next cycle on. Bit 4 = 1 makes port A input, bit 1 does the same for port B, bit 3 for port C bits 7:4 and bit 0 for port C bits 3:0. An output-enable is 1 exactly when its group is output.
- R5: A control write with bit 7 = 1 also clears the A, B and C output latches to 0 on that edge.
- R6: A control write with bit 7 = 0 loads bit 0 of the word into the port C latch bit whose index is given by bits 3:1. It leaves the other seven port C bits, ports A and B, and the directions as they were.
- R7: A data write to port A, B or C loads the whole byte into that port's latch. The value stays on `pa_out`/`pb_out`/`pc_out` after the strobe is released.
- R8: A read of a port configured as input returns the live input pins during that same cycle.
- R9: A read of a port configured as output returns its latch, whatever the input pins carry.
- R10: A port C read combines the two halves independently. Each half returns the pins if that half is input, and the latch if it is output.
- R11: A read of address 3 returns the last direction word written, or 8'h9B after reset. Bit set/clear words do not alter it.
- R12: The group-mode bits 6:5 and 2 of a direction word are stored and read back, but the port behaviour is the same as for mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Block select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not read |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output-enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output-enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_hi_oe | output | 1 | Output-enable for port C bits 7:4 |
| pc_lo_oe | output | 1 | Output-enable for port C bits 3:0 |

## Verification
The bench targets port C with its halves set in opposite directions. A design that decoded the two direction bits as one would return the latch or the pins for the whole byte. It issues bit set/clear words at the lowest and highest bit index and then reads the control word. A wrong index decode would flip a neighbouring bit, and storing those words would corrupt the readback. It also writes with `cs_n` high and reads while the pins carry different values from the latches, so a block that ignored the select or returned the wrong source on a read shows a mismatch. Random mixes of direction words, including nonzero mode bits, confirm that every redefinition wipes the latches.

// File: rtl/gpio_tp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the triple parallel port controller.
// Assumes byte-wide ports with port C split into two equal halves.
package gpio_tp_pkg;
    localparam int DATA_W  = 8;
    localparam int HALF_W  = DATA_W / 2;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Field positions inside a control write
    localparam int DEF_FLAG_BIT = 7;
    localparam int A_IN_BIT     = 4;
    localparam int CU_IN_BIT    = 3;
    localparam int B_IN_BIT     = 1;
    localparam int CL_IN_BIT    = 0;
    localparam int BSR_VAL_BIT  = 0;
    localparam int BSR_IDX_LSB  = 1;

    localparam logic [DATA_W-1:0] CTRL_RST = 8'h9B;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } dir_t;
endpackage

// File: rtl/gpio_tp_cfg.sv
`timescale 1ns/1ps
// Control word register: splits a control write into its two kinds,
// keeps the last direction word and decodes the group directions.
// Assumes wr_ctrl is already qualified by select, strobe and address.
module gpio_tp_cfg
    import gpio_tp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic              def_stb,
    output logic              bsr_stb,
    output logic [DATA_W-1:0] ctrl_q,
    output dir_t              dir
);
    // Classify the control write by its top bit
    assign def_stb = wr_ctrl &&  wdata[DEF_FLAG_BIT];
    assign bsr_stb = wr_ctrl && !wdata[DEF_FLAG_BIT];

    // Hold the last direction word
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RST;
        else if (def_stb) ctrl_q <= wdata;
    end

    // Decode group directions; mode fields are carried but not acted on
    always_comb begin
        dir.a_in  = ctrl_q[A_IN_BIT];
        dir.b_in  = ctrl_q[B_IN_BIT];
        dir.cu_in = ctrl_q[CU_IN_BIT];
        dir.cl_in = ctrl_q[CL_IN_BIT];
    end

    // R4: directions only move on a direction write
    p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !def_stb |=> $stable(dir))
        else $error("direction changed without a definition write");

    // R11: a bit set/clear word leaves the stored control word alone
    p_ctrl_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_stb |=> $stable(ctrl_q))
        else $error("control word altered by bit set/clear");
endmodule

// File: rtl/gpio_tp_latch.sv
`timescale 1ns/1ps
// Output latches for ports A, B and C, including single-bit set/clear
// on port C. Assumes at most one strobe class is active per cycle.
module gpio_tp_latch
    import gpio_tp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              wr_c,
    input  logic              def_stb,
    input  logic              bsr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q,
    output logic [DATA_W-1:0] c_q
);
    logic [IDX_W-1:0] bsr_idx;
    assign bsr_idx = wdata[BSR_IDX_LSB +: IDX_W];

    // Port A latch: cleared by reset or redefinition, loaded by data write
    always_ff @(posedge clk) begin
        if (!rst_n)       a_q <= '0;
        else if (def_stb) a_q <= '0;
        else if (wr_a)    a_q <= wdata;
    end

    // Port B latch: same policy as port A
    always_ff @(posedge clk) begin
        if (!rst_n)       b_q <= '0;
        else if (def_stb) b_q <= '0;
        else if (wr_b)    b_q <= wdata;
    end

    // Port C latch, one flop per bit so set/clear targets a single bit
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_cbit
        always_ff @(posedge clk) begin
            if (!rst_n)                                 c_q[gi] <= 1'b0;
            else if (def_stb)                           c_q[gi] <= 1'b0;
            else if (wr_c)                              c_q[gi] <= wdata[gi];
            else if (bsr_stb && (bsr_idx == IDX_W'(gi))) c_q[gi] <= wdata[BSR_VAL_BIT];
        end
    end

    // R5: redefinition empties every latch
    p_def_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        def_stb |=> (a_q == '0 && b_q == '0 && c_q == '0))
        else $error("latches not cleared by definition write");

    // R6: set/clear touches at most one port C bit and no other port
    p_bsr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_stb |=> ($countones(c_q ^ $past(c_q)) <= 1 && $stable(a_q) && $stable(b_q)))
        else $error("bit set/clear changed more than one bit");
endmodule

// File: rtl/gpio_tp_rdmux.sv
`timescale 1ns/1ps
// Host read path: picks latch or live pins per direction group and
// returns zero when no read is in progress. Purely combinational.
module gpio_tp_rdmux
    import gpio_tp_pkg::*;
(
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] sel,
    input  dir_t              dir,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] a_q,
    input  logic [DATA_W-1:0] b_q,
    input  logic [DATA_W-1:0] c_q,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_in,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] a_view, b_view, c_view;

    assign a_view = dir.a_in ? pa_in : a_q;
    assign b_view = dir.b_in ? pb_in : b_q;

    // Port C view built half by half
    for (genvar gh = 0; gh < 2; gh++) begin : g_half
        logic half_in;
        assign half_in = (gh == 0) ? dir.cl_in : dir.cu_in;
        assign c_view[gh*HALF_W +: HALF_W] =
            half_in ? pc_in[gh*HALF_W +: HALF_W] : c_q[gh*HALF_W +: HALF_W];
    end

    // Select the addressed view during a read
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_sel_e'(sel))
                SEL_A:    rdata = a_view;
                SEL_B:    rdata = b_view;
                SEL_C:    rdata = c_view;
                SEL_CTRL: rdata = ctrl_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_triport.sv
`timescale 1ns/1ps
// Top of the triple parallel port controller: qualifies host strobes,
// ties the control register, output latches and read path together and
// exposes per-group output-enables for external pad drivers.
module gpio_triport
    import gpio_tp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic              pc_hi_oe,
    output logic              pc_lo_oe
);
    logic              wr_en, rd_en;
    logic              wr_a, wr_b, wr_c, wr_ctrl;
    logic              def_stb, bsr_stb;
    logic [DATA_W-1:0] ctrl_q, a_q, b_q, c_q;
    dir_t              dir;

    // Qualify strobes with the select and decode the address
    assign wr_en   = !cs_n && !wr_n;
    assign rd_en   = !cs_n && !rd_n;
    assign wr_a    = wr_en && (reg_sel_e'(addr) == SEL_A);
    assign wr_b    = wr_en && (reg_sel_e'(addr) == SEL_B);
    assign wr_c    = wr_en && (reg_sel_e'(addr) == SEL_C);
    assign wr_ctrl = wr_en && (reg_sel_e'(addr) == SEL_CTRL);

    gpio_tp_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (wdata),
        .def_stb (def_stb),
        .bsr_stb (bsr_stb),
        .ctrl_q  (ctrl_q),
        .dir     (dir)
    );

    gpio_tp_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_c    (wr_c),
        .def_stb (def_stb),
        .bsr_stb (bsr_stb),
        .wdata   (wdata),
        .a_q     (a_q),
        .b_q     (b_q),
        .c_q     (c_q)
    );

    gpio_tp_rdmux u_rdmux (
        .rd_en  (rd_en),
        .sel    (addr),
        .dir    (dir),
        .ctrl_q (ctrl_q),
        .a_q    (a_q),
        .b_q    (b_q),
        .c_q    (c_q),
        .pa_in  (pa_in),
        .pb_in  (pb_in),
        .pc_in  (pc_in),
        .rdata  (rdata)
    );

    // Drive pins from latches and enables from decoded directions
    assign pa_out   = a_q;
    assign pb_out   = b_q;
    assign pc_out   = c_q;
    assign pa_oe    = !dir.a_in;
    assign pb_oe    = !dir.b_in;
    assign pc_hi_oe = !dir.cu_in;
    assign pc_lo_oe = !dir.cl_in;

    // R3: a deselected block keeps all of its state
    p_cs_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable({a_q, b_q, c_q, ctrl_q}))
        else $error("state changed while deselected");
endmodule

// File: tb/gpio_triport_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a reference model kept in bench variables.
module gpio_triport_tb_top;
    localparam real CLK_NS   = 5.0;
    localparam int  WD_CYC   = 150000;
    localparam int  N_RANDOM = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe, pc_hi_oe, pc_lo_oe;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // Reference model state
    logic [7:0] m_ctrl, m_a, m_b, m_c;

    always #(CLK_NS/2.0) clk = ~clk;

    gpio_triport dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_hi_oe(pc_hi_oe), .pc_lo_oe(pc_lo_oe)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a, input bit sel);
        logic [7:0] cv;
        if (!sel) return 8'h00;
        cv[7:4] = m_ctrl[3] ? pc_in[7:4] : m_c[7:4];
        cv[3:0] = m_ctrl[0] ? pc_in[3:0] : m_c[3:0];
        case (a)
            2'd0:    return m_ctrl[4] ? pa_in : m_a;
            2'd1:    return m_ctrl[1] ? pb_in : m_b;
            2'd2:    return cv;
            default: return m_ctrl;
        endcase
    endfunction

    function automatic logic [27:0] exp_pins();
        return {m_a, m_b, m_c, ~m_ctrl[4], ~m_ctrl[1], ~m_ctrl[3], ~m_ctrl[0]};
    endfunction

    task automatic compare(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pins(input string req);
        compare(req, {4'h0, pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe},
                {4'h0, exp_pins()});
    endtask

    // One-cycle host write; model follows only when selected
    task automatic host_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
        @(negedge clk);
        cs_n = !sel; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        if (sel) begin
            case (a)
                2'd0: m_a = d;
                2'd1: m_b = d;
                2'd2: m_c = d;
                default: begin
                    if (d[7]) begin m_ctrl = d; m_a = '0; m_b = '0; m_c = '0; end
                    else m_c[d[3:1]] = d[0];
                end
            endcase
        end
    endtask

    // Combinational host read, sampled 1 ns after inputs settle
    task automatic host_read(input string req, input logic [1:0] a, input bit sel,
                             input logic [7:0] ia, input logic [7:0] ib, input logic [7:0] ic);
        @(negedge clk);
        pa_in = ia; pb_in = ib; pc_in = ic;
        cs_n = !sel; rd_n = 1'b0; addr = a;
        #1;
        compare(req, {24'h0, rdata}, {24'h0, exp_read(a, sel)});
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    initial begin : watchdog
        #(CLK_NS * WD_CYC);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'h5EED_2024;
        void'($urandom(seed));
        m_ctrl = 8'h9B; m_a = '0; m_b = '0; m_c = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the pins and in the control readback
        check_pins("R1");
        host_read("R1 R11 ctrl after reset", 2'd3, 1'b1, 8'h00, 8'h00, 8'h00);
        // R8: all inputs after reset, live pins returned
        host_read("R8 R2 port A input", 2'd0, 1'b1, 8'hA5, 8'h3C, 8'h96);
        host_read("R8 R2 port B input", 2'd1, 1'b1, 8'h11, 8'hEE, 8'h96);
        host_read("R8 R10 port C input", 2'd2, 1'b1, 8'h00, 8'h00, 8'h69);
        // R4: all outputs
        host_write(2'd3, 8'h80, 1'b1);
        check_pins("R4 all output");
        // R7: data held on pins after the strobe
        host_write(2'd0, 8'h5A, 1'b1);
        host_write(2'd1, 8'hC3, 1'b1);
        host_write(2'd2, 8'hE7, 1'b1);
        @(negedge clk);
        check_pins("R7 latched outputs");
        // R9: output reads ignore pin values
        host_read("R9 R2 port A latch", 2'd0, 1'b1, 8'hFF, 8'hFF, 8'hFF);
        host_read("R9 R2 port B latch", 2'd1, 1'b1, 8'h00, 8'h00, 8'h00);
        // R6: set/clear at bit 0 and bit 7
        host_write(2'd3, 8'h00, 1'b1);
        check_pins("R6 clear bit 0");
        host_write(2'd3, 8'h0E, 1'b1);
        check_pins("R6 clear bit 7");
        host_write(2'd3, 8'h09, 1'b1);
        check_pins("R6 set bit 4");
        host_read("R11 ctrl unchanged by set/clear", 2'd3, 1'b1, 8'h00, 8'h00, 8'h00);
        // R5: redefinition clears; R10 split port C
        host_write(2'd3, 8'h88, 1'b1);
        check_pins("R5 R4 clear and C upper input");
        host_write(2'd2, 8'hFF, 1'b1);
        host_read("R10 mixed halves", 2'd2, 1'b1, 8'h00, 8'h00, 8'h3C);
        host_write(2'd3, 8'h81, 1'b1);
        host_write(2'd2, 8'hA0, 1'b1);
        host_read("R10 mixed halves swapped", 2'd2, 1'b1, 8'h00, 8'h00, 8'h5C);
        // R3: deselected writes and reads
        host_write(2'd0, 8'h77, 1'b0);
        host_write(2'd3, 8'h9B, 1'b0);
        check_pins("R3 write ignored");
        host_read("R3 deselected read", 2'd3, 1'b0, 8'hFF, 8'hFF, 8'hFF);
        // R12: mode bits stored but behaviour is basic
        host_write(2'd3, 8'hE4, 1'b1);
        check_pins("R12 mode bits ignored");
        host_write(2'd1, 8'h42, 1'b1);
        host_read("R12 readback", 2'd3, 1'b1, 8'h00, 8'h00, 8'h00);
        host_read("R12 port B latch", 2'd1, 1'b1, 8'h99, 8'h99, 8'h99);

        // Random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            int unsigned op = $urandom % 4;
            bit sel = ($urandom % 8) != 0;
            logic [1:0] a = 2'($urandom);
            logic [7:0] d = 8'($urandom);
            if (op < 2) begin
                if (a == 2'd3 && ($urandom % 4) != 0) d[7] = 1'b0;
                host_write(a, d, sel);
                check_pins(d[7] && a == 2'd3 ? "R5 R4 random definition" : "R6 R7 R3 random write");
            end else begin
                host_read("R8 R9 R10 R11 R3 random read", a, sel,
                          8'($urandom), 8'($urandom), 8'($urandom));
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule